// File: doc/BRIEF.md
# Outbound Link Wall Filter

This block guards the four outbound mesh links of one router. Software marks any link as a protection boundary by setting a wall bit for its direction. The block checks each packet on its first (header) word. If a packet's header reaches a walled link, the block does not send it. The link stalls, and an interrupt is raised to system software. Links whose wall bit is clear pass words straight through, with no register in the path.

A small register port gives software two things. The first is the wall bits. The second is a status word. The status word holds the direction and header word of the first blocked attempt, and a mask of every link that is currently stalled. Any write to the status word clears the fault. Each stalled link then drains its held packet: every word up to and including the packet's last word is accepted and thrown away. The link then checks its next header as a new packet. Only packet starts are checked. A packet already in flight finishes, even if its link is walled while it is being sent.

Top module: `hwall_filter`

## Requirements
- R1: After reset the wall bits read 0, the status word reads 0, the interrupt is low, and every link is open.
- R2: On a link whose wall bit is clear, each word goes out in the same cycle it is presented. Data and the last flag pass unchanged, and srcReady equals dstReady.
- R3: A header word presented on a link whose wall bit is set is not forwarded. From that cycle until the fault is cleared, the link drives dstValid low and srcReady low.
- R4: The interrupt rises in the cycle after a blocked header is first presented. It stays high until a write to the status address (cfgAddr=1).
- R5: The status word reads as {header[DATA_W-1:0], stalledMask[3:0], firstDir[1:0], pending}. With DATA_W=32, pending is bit 0, firstDir is bits 2:1, the mask is bits 6:3 and the header is bits 38:7. Direction d is link index d. The first blocked attempt is kept while pending stays set. A later block sets only its mask bit.
- R6: A write to the status address clears pending, the mask, the direction, the header and the interrupt. Each stalled link then accepts and discards its held packet up to its last word without sending any of it. After that, its next header is checked again.
- R7: The check is made only on a header word. A wall set in the middle of a packet lets that packet finish. Clearing a wall while its link is stalled does not release the held packet; the packet is still discarded.
- R8: A write to address 0 loads the wall bits (bit d walls link d), and a read at address 0 returns them. A header presented in the same cycle as the write is judged by the old wall value.
- R9: When headers are blocked on several links in the same cycle, the lowest link index is recorded as the direction and its header as the header word, and every one of those links has its mask bit set.
- R10: While one link is stalled, the other links keep passing or blocking traffic on their own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| srcValid | input | 4 | Per-link word valid from the router |
| srcData | input | 4*DATA_W | Per-link word, link d at bits d*DATA_W and up |
| srcLast | input | 4 | Per-link last word of packet |
| srcReady | output | 4 | Per-link word accepted |
| dstValid | output | 4 | Per-link word valid toward the neighbour |
| dstData | output | 4*DATA_W | Per-link word toward the neighbour |
| dstLast | output | 4 | Per-link last word toward the neighbour |
| dstReady | input | 4 | Per-link neighbour can take a word |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 1 | 0 selects the wall bits, 1 selects the status word |
| cfgWrData | input | 4 | Wall bits to write (ignored for the status address) |
| cfgRdData | output | DATA_W+7 | Read data for the selected register |
| faultIrq | output | 1 | Interrupt to system software |

## Verification
Forwarding, srcReady and the read data are combinational, so their expected values are due in the same cycle the stimulus is presented. The interrupt, the status word, the wall bits and each link's state change one edge after the cycle that causes them. The bench drives inputs just after a rising edge and compares every output on the falling edge, against a behavioural model of each link and of the status. The model's state moves forward only on the rising edge, using the inputs it saw at the falling edge. That gives exactly the one-edge delay the requirements state. Directed reads of the status word are taken several cycles after a block, so each captured field has settled.

// File: rtl/hwall_pkg.sv
package hwall_pkg;
  // number of outbound mesh links guarded by one filter
  parameter int unsigned LINK_CNT = 4;
  localparam int unsigned DIR_W = $clog2(LINK_CNT);

  typedef enum logic [1:0] {
    LNK_IDLE  = 2'd0, // at a packet boundary, next word is a header
    LNK_PASS  = 2'd1, // inside a forwarded packet
    LNK_HELD  = 2'd2, // header blocked, waiting for software
    LNK_DRAIN = 2'd3  // discarding the blocked packet
  } linkState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic [LINK_CNT-1:0] fwd;     // link forwards this cycle
    logic [LINK_CNT-1:0] sink;    // link swallows words this cycle
    logic                capture; // record a header word
    logic                wipe;    // status cleared by software
    logic [DIR_W-1:0]    capDir;  // link whose header is recorded
  } strobe_t;
endpackage

// File: rtl/hwall_ctrl.sv
module hwall_ctrl
  import hwall_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic [LINK_CNT-1:0] srcValid,
  input  logic [LINK_CNT-1:0] srcLast,
  input  logic [LINK_CNT-1:0] dstReady,
  input  logic                cfgWrEn,
  input  logic                cfgAddr,
  input  logic [LINK_CNT-1:0] cfgWrData,
  output strobe_t             strobe,
  output logic [LINK_CNT-1:0] wallBits,
  output logic [LINK_CNT-1:0] faultMask,
  output logic                faultPend,
  output logic [DIR_W-1:0]    faultDir
);
  logic wipeReq;
  logic wallWr;
  logic [LINK_CNT-1:0] heldNow;
  logic [LINK_CNT-1:0] fwdVec;
  logic [LINK_CNT-1:0] sinkVec;
  logic [DIR_W-1:0]    firstDir;
  logic                captureNow;

  assign wipeReq = cfgWrEn & cfgAddr;
  assign wallWr  = cfgWrEn & ~cfgAddr;

  generate
    for (genvar d = 0; d < LINK_CNT; d++) begin : g_link
      linkState_t st;
      linkState_t stNext;
      logic       acc;

      assign fwdVec[d]  = ((st == LNK_IDLE) & ~wallBits[d]) | (st == LNK_PASS);
      assign sinkVec[d] = (st == LNK_DRAIN);
      assign heldNow[d] = (st == LNK_IDLE) & srcValid[d] & wallBits[d];
      assign acc        = srcValid[d] & (fwdVec[d] ? dstReady[d] : sinkVec[d]);

      always_comb begin
        stNext = st;
        unique case (st)
          LNK_IDLE: begin
            if (heldNow[d])              stNext = LNK_HELD;
            else if (acc && !srcLast[d]) stNext = LNK_PASS;
          end
          LNK_PASS:  if (acc && srcLast[d]) stNext = LNK_IDLE;
          LNK_HELD:  if (wipeReq)           stNext = LNK_DRAIN;
          LNK_DRAIN: if (acc && srcLast[d]) stNext = LNK_IDLE;
          default:                          stNext = LNK_IDLE;
        endcase
      end

      always_ff @(posedge clk) begin
        if (rst) st <= LNK_IDLE;
        else     st <= stNext;
      end
    end
  endgenerate

  // lowest index wins when several headers are blocked together
  always_comb begin
    firstDir = '0;
    for (int i = LINK_CNT - 1; i >= 0; i--) begin
      if (heldNow[i]) firstDir = DIR_W'(i);
    end
  end

  assign captureNow = (|heldNow) & (~faultPend | wipeReq);

  always_comb begin
    strobe.fwd     = fwdVec;
    strobe.sink    = sinkVec;
    strobe.capture = captureNow;
    strobe.wipe    = wipeReq;
    strobe.capDir  = firstDir;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wallBits  <= '0;
      faultMask <= '0;
      faultPend <= 1'b0;
      faultDir  <= '0;
    end else begin
      if (wallWr) wallBits <= cfgWrData;
      faultMask <= (wipeReq ? '0 : faultMask) | heldNow;
      faultPend <= (faultPend & ~wipeReq) | (|heldNow);
      if (captureNow)   faultDir <= firstDir;
      else if (wipeReq) faultDir <= '0;
    end
  end
endmodule

// File: rtl/hwall_datapath.sv
module hwall_datapath
  import hwall_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned RD_W  = DATA_W + 1 + DIR_W + LINK_CNT
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    strobe,
  input  logic [LINK_CNT-1:0]        srcValid,
  input  logic [LINK_CNT*DATA_W-1:0] srcData,
  input  logic [LINK_CNT-1:0]        srcLast,
  input  logic [LINK_CNT-1:0]        dstReady,
  output logic [LINK_CNT-1:0]        srcReady,
  output logic [LINK_CNT-1:0]        dstValid,
  output logic [LINK_CNT*DATA_W-1:0] dstData,
  output logic [LINK_CNT-1:0]        dstLast,
  input  logic                       cfgAddr,
  input  logic [LINK_CNT-1:0]        wallBits,
  input  logic [LINK_CNT-1:0]        faultMask,
  input  logic                       faultPend,
  input  logic [DIR_W-1:0]           faultDir,
  output logic [RD_W-1:0]            cfgRdData
);
  logic [DATA_W-1:0] hdrWord;

  // open links are wires: no register between source and neighbour
  assign dstValid = srcValid & strobe.fwd;
  assign dstData  = srcData;
  assign dstLast  = srcLast & strobe.fwd;
  assign srcReady = (strobe.fwd & dstReady) | strobe.sink;

  always_ff @(posedge clk) begin
    if (rst)                 hdrWord <= '0;
    else if (strobe.capture) hdrWord <= srcData[strobe.capDir*DATA_W +: DATA_W];
    else if (strobe.wipe)    hdrWord <= '0;
  end

  always_comb begin
    if (cfgAddr) cfgRdData = {hdrWord, faultMask, faultDir, faultPend};
    else         cfgRdData = RD_W'(wallBits);
  end
endmodule

// File: rtl/hwall_filter.sv
module hwall_filter
  import hwall_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned RD_W  = DATA_W + 1 + DIR_W + LINK_CNT
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LINK_CNT-1:0]        srcValid,
  input  logic [LINK_CNT*DATA_W-1:0] srcData,
  input  logic [LINK_CNT-1:0]        srcLast,
  output logic [LINK_CNT-1:0]        srcReady,
  output logic [LINK_CNT-1:0]        dstValid,
  output logic [LINK_CNT*DATA_W-1:0] dstData,
  output logic [LINK_CNT-1:0]        dstLast,
  input  logic [LINK_CNT-1:0]        dstReady,
  input  logic                       cfgWrEn,
  input  logic                       cfgAddr,
  input  logic [LINK_CNT-1:0]        cfgWrData,
  output logic [RD_W-1:0]            cfgRdData,
  output logic                       faultIrq
);
  strobe_t             strobe;
  logic [LINK_CNT-1:0] wallBits;
  logic [LINK_CNT-1:0] faultMask;
  logic                faultPend;
  logic [DIR_W-1:0]    faultDir;

  hwall_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .srcValid(srcValid), .srcLast(srcLast), .dstReady(dstReady),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .strobe(strobe), .wallBits(wallBits), .faultMask(faultMask),
    .faultPend(faultPend), .faultDir(faultDir)
  );

  hwall_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe),
    .srcValid(srcValid), .srcData(srcData), .srcLast(srcLast),
    .dstReady(dstReady), .srcReady(srcReady), .dstValid(dstValid),
    .dstData(dstData), .dstLast(dstLast), .cfgAddr(cfgAddr),
    .wallBits(wallBits), .faultMask(faultMask), .faultPend(faultPend),
    .faultDir(faultDir), .cfgRdData(cfgRdData)
  );

  assign faultIrq = faultPend;
endmodule

// File: rtl/hwall_filter_sva.sv
module hwall_filter_sva
  import hwall_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic [LINK_CNT-1:0] srcValid,
  input logic [LINK_CNT-1:0] srcReady,
  input logic [LINK_CNT-1:0] dstValid,
  input logic                cfgWrEn,
  input logic                cfgAddr,
  input logic                faultIrq,
  input logic [LINK_CNT-1:0] faultMask,
  input logic [LINK_CNT-1:0] wallBits
);
  AST_FWD_NEEDS_SRC: assert property (@(posedge clk) disable iff (rst)
    (dstValid & ~srcValid) == '0); // R2

  AST_HELD_SILENT: assert property (@(posedge clk) disable iff (rst)
    (faultMask & (dstValid | srcReady)) == '0); // R3

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
    faultIrq && !(cfgWrEn && cfgAddr) |=> faultIrq); // R4

  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(faultIrq) |-> $past((srcValid & wallBits) != '0)); // R4

  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (rst)
    $fell(faultIrq) |-> $past(cfgWrEn && cfgAddr)); // R6
endmodule

bind hwall_filter hwall_filter_sva u_sva (
  .clk(clk), .rst(rst), .srcValid(srcValid), .srcReady(srcReady),
  .dstValid(dstValid), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
  .faultIrq(faultIrq), .faultMask(faultMask), .wallBits(wallBits)
);

// File: tb/hwall_filter_test.sv
module hwall_filter_test;
  import hwall_pkg::*;
  localparam int W = 32;
  localparam int N = LINK_CNT;
  localparam int RD_W = W + 1 + DIR_W + N;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [N-1:0]   srcValid = '0, srcLast = '0, dstReady = '1, cfgWrData = '0;
  logic [N*W-1:0] srcData = '0;
  logic           cfgWrEn = 1'b0, cfgAddr = 1'b0;
  logic [N-1:0]   srcReady, dstValid, dstLast;
  logic [N*W-1:0] dstData;
  logic [RD_W-1:0] cfgRdData;
  logic           faultIrq;

  hwall_filter #(.DATA_W(W)) uut (
    .clk(clk), .rst(rst), .srcValid(srcValid), .srcData(srcData),
    .srcLast(srcLast), .srcReady(srcReady), .dstValid(dstValid),
    .dstData(dstData), .dstLast(dstLast), .dstReady(dstReady),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .faultIrq(faultIrq)
  );

  int errors = 0;
  int checks = 0;
  string curReq = "R1";
  logic bpOn = 1'b0;
  int bpCnt = 0;

  task automatic verify(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int            mSt[N];   // 0 idle, 1 passing, 2 held, 3 draining
  int            nSt[N];
  logic [N-1:0]  mWall, mMask, nWall, nMask;
  logic          mPend, nPend;
  int            mDir, nDir;
  logic [W-1:0]  mHdr, nHdr;

  always @(negedge clk) begin
    if (!rst) begin
      bit clr;
      int firstD;
      logic [N-1:0] newMask;
      logic [RD_W-1:0] expRd;
      clr = cfgWrEn && cfgAddr;
      firstD = -1;
      newMask = '0;
      for (int d = 0; d < N; d++) begin
        bit fwd, sink, hs, eRdy;
        fwd  = (mSt[d] == 0 && !mWall[d]) || mSt[d] == 1;
        sink = (mSt[d] == 3);
        eRdy = fwd ? dstReady[d] : sink;
        hs   = srcValid[d] && eRdy;
        verify(dstValid[d] == (srcValid[d] && fwd), curReq, "dstValid", 64'(dstValid[d]), 64'(srcValid[d] && fwd));
        verify(srcReady[d] == eRdy, curReq, "srcReady", 64'(srcReady[d]), 64'(eRdy));
        if (srcValid[d] && fwd) begin
          verify(dstData[d*W +: W] == srcData[d*W +: W], curReq, "dstData", 64'(dstData[d*W +: W]), 64'(srcData[d*W +: W]));
          verify(dstLast[d] == srcLast[d], curReq, "dstLast", 64'(dstLast[d]), 64'(srcLast[d]));
        end
        nSt[d] = mSt[d];
        case (mSt[d])
          0: if (srcValid[d] && mWall[d]) begin
               nSt[d] = 2; newMask[d] = 1'b1;
               if (firstD < 0) firstD = d;
             end else if (hs && !srcLast[d]) nSt[d] = 1;
          1: if (hs && srcLast[d]) nSt[d] = 0;
          2: if (clr) nSt[d] = 3;
          default: if (hs && srcLast[d]) nSt[d] = 0;
        endcase
      end
      verify(faultIrq == mPend, curReq, "faultIrq", 64'(faultIrq), 64'(mPend));
      expRd = cfgAddr ? {mHdr, mMask, DIR_W'(mDir), mPend} : RD_W'(mWall);
      verify(cfgRdData == expRd, curReq, "cfgRdData", 64'(cfgRdData), 64'(expRd));
      nMask = (clr ? '0 : mMask) | newMask;
      nPend = (clr ? 1'b0 : mPend) | (newMask != '0);
      nDir = mDir; nHdr = mHdr;
      if (firstD >= 0 && (!mPend || clr)) begin
        nDir = firstD; nHdr = srcData[firstD*W +: W];
      end else if (clr) begin
        nDir = 0; nHdr = '0;
      end
      nWall = (cfgWrEn && !cfgAddr) ? cfgWrData : mWall;
    end
  end

  always @(posedge clk) begin
    if (rst) begin
      for (int d = 0; d < N; d++) mSt[d] <= 0;
      mWall <= '0; mMask <= '0; mPend <= 1'b0; mDir <= 0; mHdr <= '0;
    end else begin
      for (int d = 0; d < N; d++) mSt[d] <= nSt[d];
      mWall <= nWall; mMask <= nMask; mPend <= nPend; mDir <= nDir; mHdr <= nHdr;
    end
  end

  // neighbour backpressure pattern
  always @(posedge clk) begin
    #1;
    bpCnt++;
    for (int d = 0; d < N; d++) dstReady[d] = !bpOn || (((bpCnt + 3 * d) % 5) != 0);
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic regWrite(logic addr, logic [N-1:0] data);
    cfgWrEn = 1'b1; cfgAddr = addr; cfgWrData = data;
    @(posedge clk); #1;
    cfgWrEn = 1'b0; cfgAddr = 1'b1;
  endtask

  task automatic pushPacket(int d, logic [W-1:0] base, int len);
    for (int i = 0; i < len; i++) begin
      srcValid[d] = 1'b1;
      srcData[d*W +: W] = base + W'(i);
      srcLast[d] = (i == len - 1);
      forever begin
        @(negedge clk);
        if (srcReady[d]) break;
      end
      @(posedge clk); #1;
    end
    srcValid[d] = 1'b0;
    srcLast[d] = 1'b0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R6 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    verify(faultIrq == 1'b0, "R1", "irq after reset", 64'(faultIrq), 64'd0);
    verify(cfgRdData == '0, "R1", "wall bits after reset", 64'(cfgRdData), 64'd0);
    verify(dstValid == '0, "R1", "dstValid after reset", 64'(dstValid), 64'd0);
    @(posedge clk); #1;
    cfgAddr = 1'b1;
    @(negedge clk);
    verify(cfgRdData == '0, "R1", "status after reset", 64'(cfgRdData), 64'd0);
    @(posedge clk); #1;

    // open links, all four busy, with backpressure
    curReq = "R2";
    bpOn = 1'b1;
    fork
      pushPacket(0, 32'h100, 5);
      pushPacket(1, 32'h200, 3);
      pushPacket(2, 32'h300, 1);
      pushPacket(3, 32'h400, 7);
    join
    pushPacket(0, 32'h110, 4);
    bpOn = 1'b0;
    idle(1);

    // wall write and readback; header in the write cycle uses the old value
    curReq = "R8";
    fork
      regWrite(1'b0, 4'b0010);
      pushPacket(1, 32'h500, 3);
    join
    regWrite(1'b0, 4'b1010);
    cfgAddr = 1'b0;
    @(negedge clk);
    verify(cfgRdData == RD_W'(4'b1010), "R8", "wall readback", 64'(cfgRdData), 64'hA);
    @(posedge clk); #1;
    regWrite(1'b0, 4'b0100);

    // blocked header, interrupt, status, then clear and drain
    curReq = "R3";
    fork
      pushPacket(2, 32'h600, 4);
      begin
        idle(4);
        curReq = "R4";
        @(negedge clk);
        verify(faultIrq == 1'b1, "R4", "irq held", 64'(faultIrq), 64'd1);
        verify(cfgRdData == {32'h600, 4'b0100, 2'd2, 1'b1}, "R5", "status word",
               64'(cfgRdData), 64'({32'h600, 4'b0100, 2'd2, 1'b1}));
        @(posedge clk); #1;
        curReq = "R6";
        regWrite(1'b1, 4'b0000);
      end
    join
    regWrite(1'b0, 4'b0000);
    pushPacket(2, 32'h620, 2);

    // two links blocked in the same cycle
    regWrite(1'b0, 4'b1010);
    curReq = "R9";
    fork
      pushPacket(1, 32'h700, 3);
      pushPacket(3, 32'h800, 2);
      begin
        idle(4);
        @(negedge clk);
        verify(cfgRdData == {32'h700, 4'b1010, 2'd1, 1'b1}, "R9", "status on tie",
               64'(cfgRdData), 64'({32'h700, 4'b1010, 2'd1, 1'b1}));
        @(posedge clk); #1;
        regWrite(1'b1, 4'b0000);
      end
    join

    // one link stalled while another passes
    regWrite(1'b0, 4'b0001);
    curReq = "R10";
    bpOn = 1'b1;
    fork
      pushPacket(0, 32'h900, 3);
      pushPacket(2, 32'hA00, 6);
      begin
        idle(12);
        regWrite(1'b1, 4'b0000);
      end
    join
    bpOn = 1'b0;
    regWrite(1'b0, 4'b0000);

    // check made on headers only
    curReq = "R7";
    fork
      pushPacket(0, 32'hB00, 6);
      begin
        idle(2);
        regWrite(1'b0, 4'b0001);
      end
    join
    fork
      pushPacket(0, 32'hB10, 3);
      begin
        idle(3);
        regWrite(1'b0, 4'b0000);
        idle(2);
        regWrite(1'b1, 4'b0000);
      end
    join
    pushPacket(0, 32'hB20, 2);

    // a later block keeps the first record
    regWrite(1'b0, 4'b0110);
    curReq = "R5";
    fork
      pushPacket(1, 32'hC00, 2);
      begin
        idle(3);
        pushPacket(2, 32'hC10, 2);
      end
      begin
        idle(8);
        @(negedge clk);
        verify(cfgRdData == {32'hC00, 4'b0110, 2'd1, 1'b1}, "R5", "first fault kept",
               64'(cfgRdData), 64'({32'hC00, 4'b0110, 2'd1, 1'b1}));
        @(posedge clk); #1;
        regWrite(1'b1, 4'b0000);
      end
    join
    regWrite(1'b0, 4'b0000);
    idle(3);
    summary();
    $finish;
  end
endmodule